// File: doc/BRIEF.md
# Fractional Clock Divider Generator

This block derives a slower clock from a fast input clock. The divisor is fixed-point, with an integer part and a fractional part. The fractional part drives a small accumulator. The accumulator lengthens an output period by one input cycle each time it overflows, so the average period over many periods equals the programmed divisor. The block drives two outputs. The first is a divided clock, built from registers in the input clock domain. The second is a one-input-cycle enable pulse at the start of every output period, for logic that runs on the input clock.

The divisor inputs may change at any time. A new value is taken only at a period boundary. Turning the generator on or off never produces a shortened pulse, and a separate kill input clears the generator at once without waiting for an edge. A two-bit phase selector delays the start and stop of the generator by zero to three input cycles. Every transition on the nudge input delays all later output edges by one input cycle. When duty correction is on, an odd period length is split evenly. To do this, the falling edge of the output moves by half an input cycle.

Top module: `fracdiv_gen`

## Requirements
- R1: While reset is asserted, and while the generator is idle, `clk_out` and `clk_en` are both 0.
- R2: With integer part N of 2 or more, a fractional part of 0 and `duty_fix` low, every output period lasts N input cycles, and `clk_out` is high for floor(N/2) of them.
- R3: An integer part of 1 holds `clk_out` high and `clk_en` high on every cycle while running.
- R4: An integer part of 0 gives a period of 65536 input cycles, high for 32768.
- R5: With fractional part F (in units of 1/256), each period lasts N or N+1 cycles. When F is a multiple of 32, any 8 consecutive periods add up to exactly 8*N + F/32 cycles.
- R6: A divisor written in the middle of a period does not change that period. The next period uses the new value in full, and the output keeps running across the change.
- R7: `clk_en` is high for exactly one input cycle per period, in the first cycle of the period, while `clk_out` is high.
- R8: When `gen_en` falls, the current period finishes with its full high and low phases. After that, `clk_out` stays low.
- R9: After a restart, the first period has its full high phase and full length.
- R10: While `kill` is high, `clk_out` and `clk_en` are low. They drop without waiting for an input clock edge.
- R11: A value of P on `phase_sel` delays the first rising edge after `gen_en` rises by exactly P input cycles, compared with P = 0.
- R12: Each transition on `nudge` (rising or falling) while running holds the period counter for one cycle. The period in progress becomes one input cycle longer, and the periods after it keep their normal length.
- R13: With `duty_fix` high and an odd period length L greater than 1, `clk_out` is high for L/2 input cycles, a whole number plus one half. The rest of the period is low. With an even L, the high time is L/2 whether or not `duty_fix` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| kill | input | 1 | Asynchronous stop; clears the generator while high |
| gen_en | input | 1 | Run request; start and stop happen on period boundaries |
| phase_sel | input | PHASE_W | Delay of the run request in input cycles |
| nudge | input | 1 | Each transition adds one input cycle to the current period |
| duty_fix | input | 1 | Equalise high and low times for odd period lengths |
| div_int | input | INT_W | Integer part of the divisor; 0 means 65536 |
| div_frac | input | FRAC_W | Fractional part of the divisor, in units of 1/256 |
| clk_out | output | 1 | Divided clock |
| clk_en | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The assertions assume three things about the inputs:
- `gen_en`, `nudge`, the divisor inputs and `phase_sel` change only away from rising edges of `clk_in`.
- `kill` is held for at least one full input cycle.
- The period counter never reaches a length the register cannot hold.

The stimulus meets these assumptions. It drives every input a quarter cycle after a clock edge, and it holds `kill` for several cycles. It keeps the integer part between 0 and 9. Because the divided clock moves on half-cycle boundaries, the bench samples twice per input cycle and does all its timing arithmetic in half-cycle units.

// File: rtl/fdg_pkg.sv
`timescale 1ns/1ps
package fdg_pkg;
  // Default geometry of the divider
  localparam int unsigned INT_W_DEF   = 24;
  localparam int unsigned FRAC_W_DEF  = 8;
  localparam int unsigned PHASE_W_DEF = 2;
  localparam int unsigned ZERO_LEN    = 65536;  // period used for an integer part of 0
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/fdg_rst_sync.sv
`timescale 1ns/1ps
// Reset bridge: clears at once, releases after STAGES input edges.
module fdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic raw_n,
  output logic sync_n
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge raw_n) begin
    if (!raw_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/fdg_phase_dly.sv
`timescale 1ns/1ps
// Selectable delay line for the run request: 0 .. 2**PHASE_W-1 cycles.
module fdg_phase_dly #(
  parameter int unsigned PHASE_W = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               req,
  input  logic [PHASE_W-1:0] sel,
  output logic               req_dly
);
  localparam int unsigned DEPTH = (1 << PHASE_W) - 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH:0]   tap;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DEPTH-2:0], req};
      end
    end
  endgenerate

  assign tap     = {pipe_q, req};
  assign req_dly = tap[sel];
endmodule

// File: rtl/fdg_core.sv
`timescale 1ns/1ps
// Period counter, fractional accumulator and start/stop sequencing.
module fdg_core #(
  parameter int unsigned INT_W    = 24,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned ZERO_LEN = 65536,
  localparam int unsigned LEN_W   = INT_W + 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              run_req,
  input  logic              hold,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              run_o,
  output logic              hi_o,
  output logic              tick_o,
  output logic              odd_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic [LEN_W-1:0]  len_o
);
  logic              run_q,  run_d;
  logic              hi_q,   hi_d;
  logic              tick_q, tick_d;
  logic [LEN_W-1:0]  cnt_q,  cnt_d;
  logic [LEN_W-1:0]  len_q,  len_d;
  logic [FRAC_W-1:0] acc_q,  acc_d;
  logic [LEN_W-1:0]  base_len;
  logic [LEN_W-1:0]  hi_len_d;
  logic [FRAC_W:0]   acc_sum;
  logic              last, load;

  // Next-state logic
  always_comb begin
    base_len = (div_int == '0) ? LEN_W'(ZERO_LEN) : {1'b0, div_int};
    acc_sum  = {1'b0, (run_q ? acc_q : {FRAC_W{1'b0}})} + {1'b0, div_frac};
    last     = (cnt_q == len_q - 1'b1);
    run_d    = run_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    acc_d    = acc_q;
    load     = 1'b0;
    if (!run_q) begin
      if (run_req) begin
        load  = 1'b1;
        run_d = 1'b1;
      end
    end else if (!hold) begin
      if (last) begin
        if (run_req) begin
          load = 1'b1;
        end else begin
          run_d = 1'b0;
          cnt_d = '0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (load) begin
      cnt_d = '0;
      len_d = base_len + LEN_W'(acc_sum[FRAC_W]);
      acc_d = acc_sum[FRAC_W-1:0];
    end
    hi_len_d = (len_d == LEN_W'(1)) ? LEN_W'(1) : (len_d >> 1);
    hi_d     = run_d && (cnt_d < hi_len_d);
    tick_d   = load;
  end

  // State registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q  <= 1'b0;
      hi_q   <= 1'b0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      acc_q  <= '0;
    end else begin
      run_q  <= run_d;
      hi_q   <= hi_d;
      tick_q <= tick_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      acc_q  <= acc_d;
    end
  end

  assign run_o  = run_q;
  assign hi_o   = hi_q;
  assign tick_o = tick_q;
  assign odd_o  = run_q && len_q[0] && (len_q != LEN_W'(1));
  assign cnt_o  = cnt_q;
  assign len_o  = len_q;
endmodule

// File: rtl/fdg_duty.sv
`timescale 1ns/1ps
// Half-cycle extension of the high phase for odd period lengths.
module fdg_duty (
  input  logic clk,
  input  logic arst_n,
  input  logic fix_en,
  input  logic hi,
  input  logic odd,
  output logic out
);
  logic half_q;

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) half_q <= 1'b0;
    else         half_q <= hi & odd & fix_en;
  end

  assign out = hi | half_q;
endmodule

// File: rtl/fracdiv_gen.sv
`timescale 1ns/1ps
module fracdiv_gen #(
  parameter int unsigned INT_W       = fdg_pkg::INT_W_DEF,
  parameter int unsigned FRAC_W      = fdg_pkg::FRAC_W_DEF,
  parameter int unsigned PHASE_W     = fdg_pkg::PHASE_W_DEF,
  parameter int unsigned ZERO_LEN    = fdg_pkg::ZERO_LEN,
  parameter int unsigned SYNC_STAGES = fdg_pkg::SYNC_DEF
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               kill,
  input  logic               gen_en,
  input  logic [PHASE_W-1:0] phase_sel,
  input  logic               nudge,
  input  logic               duty_fix,
  input  logic [INT_W-1:0]   div_int,
  input  logic [FRAC_W-1:0]  div_frac,
  output logic               clk_out,
  output logic               clk_en
);
  localparam int unsigned LEN_W = INT_W + 1;

  logic             raw_n, core_rst_n;
  logic             run_dly;
  logic             nudge_q, nudge_hold;
  logic             core_run, core_hi, core_odd;
  logic [LEN_W-1:0] core_cnt, core_len;

  assign raw_n = rst_n & ~kill;

  fdg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_in),
    .raw_n  (raw_n),
    .sync_n (core_rst_n)
  );

  fdg_phase_dly #(.PHASE_W(PHASE_W)) u_phase (
    .clk     (clk_in),
    .arst_n  (core_rst_n),
    .req     (gen_en),
    .sel     (phase_sel),
    .req_dly (run_dly)
  );

  always_ff @(posedge clk_in or negedge core_rst_n) begin
    if (!core_rst_n) nudge_q <= 1'b0;
    else             nudge_q <= nudge;
  end
  assign nudge_hold = nudge ^ nudge_q;

  fdg_core #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ZERO_LEN(ZERO_LEN)) u_core (
    .clk      (clk_in),
    .arst_n   (core_rst_n),
    .run_req  (run_dly),
    .hold     (nudge_hold),
    .div_int  (div_int),
    .div_frac (div_frac),
    .run_o    (core_run),
    .hi_o     (core_hi),
    .tick_o   (clk_en),
    .odd_o    (core_odd),
    .cnt_o    (core_cnt),
    .len_o    (core_len)
  );

  fdg_duty u_duty (
    .clk    (clk_in),
    .arst_n (core_rst_n),
    .fix_en (duty_fix),
    .hi     (core_hi),
    .odd    (core_odd),
    .out    (clk_out)
  );
endmodule

// File: rtl/fracdiv_gen_chk.sv
`timescale 1ns/1ps
module fracdiv_gen_chk #(
  parameter int unsigned LEN_W = 25
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic             kill,
  input logic             clk_out,
  input logic             clk_en,
  input logic             run,
  input logic             hi,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] len,
  input logic             hold
);
  p_idle_low_r1: assert property (@(posedge clk_in) disable iff (!rst_n || kill)
    !run |-> !hi);

  p_cnt_bound_r2: assert property (@(posedge clk_in) disable iff (!rst_n || kill)
    run |-> (cnt < len));

  p_len_at_boundary_r6: assert property (@(posedge clk_in) disable iff (!rst_n || kill)
    !$stable(len) |-> clk_en);

  p_tick_with_rise_r7: assert property (@(posedge clk_in) disable iff (!rst_n || kill)
    clk_en |-> clk_out);

  p_kill_low_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    kill |-> (!clk_out && !clk_en));

  p_nudge_hold_r12: assert property (@(posedge clk_in) disable iff (!rst_n || kill)
    (run && hold) |=> $stable(cnt));
endmodule

bind fracdiv_gen fracdiv_gen_chk #(.LEN_W(INT_W + 1)) u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .kill    (kill),
  .clk_out (clk_out),
  .clk_en  (clk_en),
  .run     (core_run),
  .hi      (core_hi),
  .cnt     (core_cnt),
  .len     (core_len),
  .hold    (nudge_hold)
);

// File: tb/fracdiv_gen_tb.sv
`timescale 1ns/1ps
module fracdiv_gen_tb;
  localparam int INT_W = 24;
  localparam int FRAC_W = 8;
  localparam int PHASE_W = 2;

  logic clk = 1'b0;
  logic rst_n, kill, gen_en, nudge, duty_fix;
  logic [PHASE_W-1:0] phase_sel;
  logic [INT_W-1:0]   div_int;
  logic [FRAC_W-1:0]  div_frac;
  logic clk_out, clk_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  fracdiv_gen u_dut (
    .clk_in(clk), .rst_n(rst_n), .kill(kill), .gen_en(gen_en),
    .phase_sel(phase_sel), .nudge(nudge), .duty_fix(duty_fix),
    .div_int(div_int), .div_frac(div_frac),
    .clk_out(clk_out), .clk_en(clk_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Advance to the first high sample of the next rising edge (half-cycle samples).
  task automatic sync_rise(input int limit);
    logic prev;
    for (int k = 0; k < limit; k++) begin
      prev = clk_out;
      #2;
      if (!prev && clk_out) break;
    end
  endtask

  // Measure one period in half cycles, starting on its first high sample.
  // act: 0 none, 1 toggle nudge, 2 drop gen_en, 3 set div_int to 6 (at half index at)
  task automatic measure(input int act, input int at, input int limit,
                         output int per, output int hi, output int ens);
    bit seen_low = 0;
    per = -1; hi = 0; ens = 0;
    for (int h = 0; h < limit; h++) begin
      if (h > 0 && clk_out && seen_low) begin
        per = h;
        break;
      end
      if (!clk_out) seen_low = 1;
      else if (!seen_low) hi++;
      if (clk_en) ens++;
      if (h == at) begin
        if (act == 1) nudge = ~nudge;
        else if (act == 2) gen_en = 1'b0;
        else if (act == 3) div_int = 6;
      end
      #2;
    end
  endtask

  initial begin
    #(4 * 195000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int per, hi, ens, bad, sum, expv;
    int lat[4];
    rst_n = 0; kill = 0; gen_en = 0; nudge = 0; duty_fix = 0;
    phase_sel = 0; div_int = 1; div_frac = 0;
    #10;
    check("R1", "clk_out in reset", int'(clk_out), 0);
    check("R1", "clk_en in reset", int'(clk_en), 0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (10) #2;
    check("R1", "clk_out idle", int'(clk_out), 0);
    check("R1", "clk_en idle", int'(clk_en), 0);

    // R2 / R13 / R7: integer sweep with and without duty correction
    gen_en = 1;
    for (int dc = 0; dc < 2; dc++) begin
      duty_fix = dc[0];
      for (int n = 2; n <= 9; n++) begin
        div_int = n;
        sync_rise(100);
        measure(0, -1, 100, per, hi, ens);
        measure(0, -1, 100, per, hi, ens);
        check("R2", $sformatf("period halves N=%0d", n), per, 2 * n);
        expv = (dc == 1) ? n : 2 * (n / 2);
        check(dc == 1 ? "R13" : "R2", $sformatf("high halves N=%0d", n), hi, expv);
        check("R7", $sformatf("enable samples N=%0d", n), ens, 2);
      end
    end
    duty_fix = 0;

    // R3: divide by one
    div_int = 1;
    repeat (40) #2;
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      if (!clk_out || !clk_en) bad++;
      #2;
    end
    check("R3", "samples not high", bad, 0);

    // R5: fractional sweep
    div_int = 4;
    for (int f = 0; f < 256; f += 32) begin
      div_frac = f;
      sync_rise(100);
      measure(0, -1, 100, per, hi, ens);
      measure(0, -1, 100, per, hi, ens);
      sum = 0; bad = 0;
      for (int k = 0; k < 8; k++) begin
        measure(0, -1, 100, per, hi, ens);
        if (per != 8 && per != 10) bad++;
        sum += per;
      end
      check("R5", $sformatf("odd period length F=%0d", f), bad, 0);
      check("R5", $sformatf("8-period halves F=%0d", f), sum, 2 * (32 + f / 32));
    end
    div_frac = 0;

    // R6: divisor change mid-period
    div_int = 4;
    sync_rise(100);
    measure(0, -1, 100, per, hi, ens);
    measure(0, -1, 100, per, hi, ens);
    measure(3, 3, 100, per, hi, ens);
    check("R6", "period during write", per, 8);
    measure(0, -1, 100, per, hi, ens);
    check("R6", "period after write", per, 12);
    check("R6", "high after write", hi, 6);

    // R12: nudge
    div_int = 8;
    sync_rise(100);
    measure(0, -1, 100, per, hi, ens);
    measure(0, -1, 100, per, hi, ens);
    measure(1, 4, 100, per, hi, ens);
    check("R12", "nudged period", per, 18);
    measure(0, -1, 100, per, hi, ens);
    check("R12", "period after nudge", per, 16);

    // R8: clean stop
    measure(2, 2, 100, per, hi, ens);
    check("R8", "high halves of last period", hi, 8);
    check("R8", "no further rise", per, -1);
    repeat (20) #2;
    check("R8", "clk_out after stop", int'(clk_out), 0);

    // R9: restart with full high phase
    gen_en = 1;
    sync_rise(100);
    measure(0, -1, 100, per, hi, ens);
    check("R9", "first high halves", hi, 8);
    check("R9", "first period halves", per, 16);

    // R11: phase delay of start
    div_int = 2;
    for (int p = 0; p < 4; p++) begin
      gen_en = 0;
      repeat (40) #2;
      phase_sel = p;
      @(posedge clk); #1;
      gen_en = 1;
      lat[p] = 0;
      while (!clk_out && lat[p] < 100) begin
        #2;
        lat[p]++;
      end
    end
    for (int p = 1; p < 4; p++)
      check("R11", $sformatf("extra start delay phase=%0d", p), lat[p] - lat[0], 2 * p);
    phase_sel = 0;

    // R10: asynchronous kill
    div_int = 8;
    sync_rise(100);
    #2;
    #0.5 kill = 1;
    #0.5;
    check("R10", "clk_out right after kill", int'(clk_out), 0);
    check("R10", "clk_en right after kill", int'(clk_en), 0);
    #1;
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      if (clk_out || clk_en) bad++;
      #2;
    end
    check("R10", "active samples while killed", bad, 0);
    kill = 0;
    sync_rise(100);
    measure(0, -1, 100, per, hi, ens);
    check("R9", "period after kill release", per, 16);

    // R4: integer part 0
    div_int = 0;
    sync_rise(140000);
    measure(0, -1, 140000, per, hi, ens);
    check("R4", "zero-divisor period halves", per, 131072);
    check("R4", "zero-divisor high halves", hi, 65536);

    summary();
  end
endmodule